// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked run of 8-byte region descriptors stored back to back in memory, starting at a base address handed in with a start pulse. It fetches one descriptor at a time through a simple read port and decodes it. For every valid descriptor it presents one region request, carrying an address, a length and the descriptor's flag byte, to a downstream data mover. The walk stops after the descriptor whose flag byte has its end marker set.

While it walks, the block keeps a running byte total. When the chain completes normally, it compares that total with the expected transfer size that was sampled at start, and reports a short transfer or a long transfer. The check for a long transfer is waived if any region asked for excess data to be drained. A region length of zero, or one above the segment ceiling, ends the walk with a length error. The walk also ends with an overrun error if no end marker has appeared after a parameterized number of regions. Every ending, normal or not, gives a single-cycle done pulse.

A command-packet region, if present, is simply the first descriptor of the chain. Its bytes count toward the total in the same way as the data bytes.

Top module: `sgw_chain_walker`

## Requirements
- R1: Each descriptor is decoded little-endian from the 64-bit read word. Bits [31:0] are the region address, bits [47:32] are the length, bits [55:48] are reserved and ignored, and bits [63:56] are the flag byte. Each region request carries that address, that length and the unchanged flag byte (bit 1 drain, bit 2 command packet, bit 3 direct interrupt, bit 4 DMA, bit 5 write, bit 6 I/O space, bit 7 end of chain).
- R2: Descriptors are fetched at chain_base + 8·k for k = 0, 1, 2, …. The walk ends after the request for the descriptor with flag bit 7 set is accepted. `done` is high for exactly one cycle, the cycle after that acceptance.
- R3: `total_len` is cleared when a walk starts. It then grows by the length of each accepted request.
- R4: When the chain ends normally with a total below `exp_total`, `underflow` is 1. Otherwise it is 0.
- R5: When the chain ends normally with a total above `exp_total`, `overflow` is 1. The exception is when any accepted region had flag bit 1 (drain) set, in which case it stays 0.
- R6: A descriptor whose length is 0 or exceeds MAX_SEG_LEN (65024 by default) produces no request. It sets `len_err`, and the walk ends with `done`. `underflow` and `overflow` stay 0 in that case.
- R7: If MAX_DESC (default 8) requests are accepted without an end marker, `overrun_err` is set, `done` pulses, and no further descriptor is fetched.
- R8: While `req_valid` is high and `req_ready` is low, the request stays asserted and its address, length and flags do not change.
- R9: `busy` is high from the cycle after an accepted start until the cycle after `done`. A start pulse while busy is ignored.
- R10: After reset, `busy`, `done`, `req_valid`, `rd_req`, `total_len` and all result flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| chain_base | input | 32 | Byte address of the first descriptor |
| exp_total | input | TOT_W | Expected total byte count, sampled at start |
| rd_req | output | 1 | Descriptor read request, one cycle |
| rd_addr | output | 32 | Descriptor byte address |
| rd_rvalid | input | 1 | Read data valid |
| rd_data | input | 64 | Descriptor word, byte 0 in bits [7:0] |
| req_valid | output | 1 | Region request valid |
| req_ready | input | 1 | Region request accepted when high with valid |
| req_addr | output | 32 | Region address |
| req_len | output | 16 | Region length in bytes |
| req_flags | output | 8 | Region flag byte |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| total_len | output | TOT_W | Sum of accepted region lengths |
| underflow | output | 1 | Normal end with total below expected |
| overflow | output | 1 | Normal end with total above expected, no drain region |
| len_err | output | 1 | Walk ended on a zero or oversize length |
| overrun_err | output | 1 | Walk ended for lack of an end marker |

## Verification
The bench goes after the off-by-one points:
- A region of exactly 65024 bytes must pass, and one byte more must fail. A wrong bound either rejects a legal maximum segment or issues an illegal one.
- A chain whose end marker sits on the MAX_DESC-th descriptor must end cleanly. One without the marker must stop with no extra fetch. An early or late counter compare would flag a legal chain or read past the limit.
- The drain flag is placed on both the first and the last region. A design that latched it from only one place would report a false overflow.
- Half the cases throttle `req_ready`, so a request that moved or dropped while stalled is seen at the port.
- The reserved byte is filled with a non-zero value, and addresses use distinct bytes. This exposes a decode with swapped or shifted fields.

// File: rtl/sgw_pkg.sv
// Shared definitions for the scatter-gather chain walker.
// Assumes the descriptor word arrives with byte 0 in bits [7:0].
package sgw_pkg;

    localparam int DESC_BYTES = 8;

    // Flag byte bit positions
    localparam int FLG_DRAIN  = 1;
    localparam int FLG_CMDPKT = 2;
    localparam int FLG_DIRQ   = 3;
    localparam int FLG_DMA    = 4;
    localparam int FLG_WRITE  = 5;
    localparam int FLG_IOSP   = 6;
    localparam int FLG_LAST   = 7;

    // One descriptor, little-endian byte order packed MSB-first
    typedef struct packed {
        logic [7:0]  flags;
        logic [7:0]  rsvd;
        logic [15:0] len;
        logic [31:0] addr;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_CHECK,
        ST_ISSUE,
        ST_FINISH
    } walk_state_e;

endpackage

// File: rtl/sgw_desc_decode.sv
// Descriptor decoder: splits a raw descriptor word into its fields and
// judges whether the length is legal. Purely combinational.
// Assumes the caller holds the word stable while it uses the outputs.
module sgw_desc_decode
    import sgw_pkg::*;
#(
    parameter int MAX_SEG_LEN = 65024
) (
    input  desc_t       raw,
    output logic [31:0] addr,
    output logic [15:0] len,
    output logic [7:0]  flags,
    output logic        is_last,
    output logic        is_drain,
    output logic        len_ok
);

    logic unused_rsvd;

    // Field extraction and length legality
    always_comb begin
        addr        = raw.addr;
        len         = raw.len;
        flags       = raw.flags;
        is_last     = raw.flags[FLG_LAST];
        is_drain    = raw.flags[FLG_DRAIN];
        len_ok      = (raw.len != 16'd0) && (32'(raw.len) <= MAX_SEG_LEN);
        unused_rsvd = ^raw.rsvd;
    end

endmodule

// File: rtl/sgw_len_acct.sv
// Length accountant: sums accepted region lengths and, at the end of a
// normal chain, compares the sum with the expected total sampled at start.
// Assumes clear and add are never high in the same cycle.
module sgw_len_acct #(
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [TOT_W-1:0] exp_in,
    input  logic             add,
    input  logic [15:0]      add_len,
    input  logic             add_drain,
    input  logic             finalize,
    output logic [TOT_W-1:0] total,
    output logic             under,
    output logic             over
);

    logic [TOT_W-1:0] exp_q;
    logic             drain_q;
    logic [TOT_W-1:0] sum;
    logic             drain_any;

    // Next running total and drain state
    always_comb begin
        sum       = total + TOT_W'(add_len);
        drain_any = drain_q | add_drain;
    end

    // Running total, drain memory and end-of-chain verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total   <= '0;
            exp_q   <= '0;
            drain_q <= 1'b0;
            under   <= 1'b0;
            over    <= 1'b0;
        end else if (clear) begin
            total   <= '0;
            exp_q   <= exp_in;
            drain_q <= 1'b0;
            under   <= 1'b0;
            over    <= 1'b0;
        end else if (add) begin
            total   <= sum;
            drain_q <= drain_any;
            if (finalize) begin
                under <= (sum < exp_q);
                over  <= (sum > exp_q) && !drain_any;
            end
        end
    end

    // R4
    short_long_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(under && over)) else $error("underflow and overflow together");

    // R3
    total_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (total == '0) && !under && !over) else $error("total not cleared");

endmodule

// File: rtl/sgw_chain_walker.sv
// Scatter-gather chain walker top. Fetches 8-byte descriptors one at a
// time, issues one region request per legal descriptor, stops on the end
// marker, a bad length, or after MAX_DESC regions, and pulses done.
// Assumes the memory answers every rd_req with exactly one rd_rvalid.
module sgw_chain_walker
    import sgw_pkg::*;
#(
    parameter int TOT_W       = 32,
    parameter int MAX_DESC    = 8,
    parameter int MAX_SEG_LEN = 65024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      chain_base,
    input  logic [TOT_W-1:0] exp_total,
    output logic             rd_req,
    output logic [31:0]      rd_addr,
    input  logic             rd_rvalid,
    input  logic [63:0]      rd_data,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_addr,
    output logic [15:0]      req_len,
    output logic [7:0]       req_flags,
    output logic             busy,
    output logic             done,
    output logic [TOT_W-1:0] total_len,
    output logic             underflow,
    output logic             overflow,
    output logic             len_err,
    output logic             overrun_err
);

    localparam int CNT_W = $clog2(MAX_DESC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_DESC - 1);

    walk_state_e      state_q;
    desc_t            desc_q;
    logic [31:0]      fetch_addr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             len_err_q;
    logic             ovr_q;

    logic        dec_last;
    logic        dec_drain;
    logic        dec_len_ok;
    logic        accept;
    logic        take_start;

    sgw_desc_decode #(
        .MAX_SEG_LEN(MAX_SEG_LEN)
    ) u_decode (
        .raw     (desc_q),
        .addr    (req_addr),
        .len     (req_len),
        .flags   (req_flags),
        .is_last (dec_last),
        .is_drain(dec_drain),
        .len_ok  (dec_len_ok)
    );

    // Handshake and status decode from the walk state
    always_comb begin
        take_start  = (state_q == ST_IDLE) && start;
        req_valid   = (state_q == ST_ISSUE);
        accept      = req_valid && req_ready;
        rd_req      = (state_q == ST_FETCH);
        rd_addr     = fetch_addr_q;
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_FINISH);
        len_err     = len_err_q;
        overrun_err = ovr_q;
    end

    sgw_len_acct #(
        .TOT_W(TOT_W)
    ) u_acct (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take_start),
        .exp_in   (exp_total),
        .add      (accept),
        .add_len  (req_len),
        .add_drain(dec_drain),
        .finalize (accept && dec_last),
        .total    (total_len),
        .under    (underflow),
        .over     (overflow)
    );

    // Walk sequencer: fetch, wait, check, issue, repeat until an ending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            desc_q       <= '0;
            fetch_addr_q <= '0;
            cnt_q        <= '0;
            len_err_q    <= 1'b0;
            ovr_q        <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    fetch_addr_q <= chain_base;
                    cnt_q        <= '0;
                    len_err_q    <= 1'b0;
                    ovr_q        <= 1'b0;
                    state_q      <= ST_FETCH;
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT: if (rd_rvalid) begin
                    desc_q  <= rd_data;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!dec_len_ok) begin
                        len_err_q <= 1'b1;
                        state_q   <= ST_FINISH;
                    end else begin
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: if (req_ready) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (dec_last) begin
                        state_q <= ST_FINISH;
                    end else if (cnt_q == CNT_LAST) begin
                        ovr_q   <= 1'b1;
                        state_q <= ST_FINISH;
                    end else begin
                        fetch_addr_q <= fetch_addr_q + 32'(DESC_BYTES);
                        state_q      <= ST_FETCH;
                    end
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr)
            && $stable(req_len) && $stable(req_flags))
        else $error("request changed while stalled");

    // R6
    bad_len_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != 16'd0) && (32'(req_len) <= MAX_SEG_LEN))
        else $error("illegal length issued");

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle");

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy && $stable(exp_total) == $stable(exp_total))
        else $error("walk dropped by start while busy");

    // R7
    desc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_DESC)) else $error("region count past limit");

    // R2
    fetch_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy && !req_valid) else $error("fetch outside a walk");

endmodule

// File: tb/test_sgw_chain_walker.sv
`timescale 1ns/1ps
module test_sgw_chain_walker;

    localparam int TOT_W = 32;
    localparam int MAX_DESC = 8;
    localparam int MAX_SEG = 65024;

    typedef struct packed {
        logic [2:0]       n;
        logic [3:0][15:0] len;
        logic [3:0][7:0]  fl;
        logic [31:0]      exp;
        logic [31:0]      tot;
        logic [3:0]       reqs;
        logic             un;
        logic             ov;
        logic             le;
    } vec_t;

    localparam int NV = 10;
    // lengths and flags listed slot 3 down to slot 0
    localparam vec_t VEC [NV] = '{
        '{3'd2, {16'd0, 16'd0, 16'd1024, 16'd512},   {8'h00, 8'h00, 8'h80, 8'h10}, 32'd1536,  32'd1536,  4'd2, 1'b0, 1'b0, 1'b0},
        '{3'd3, {16'd0, 16'd4096, 16'd2048, 16'd12}, {8'h00, 8'hB0, 8'h30, 8'h24}, 32'd6156,  32'd6156,  4'd3, 1'b0, 1'b0, 1'b0},
        '{3'd1, {16'd0, 16'd0, 16'd0, 16'd1000},     {8'h00, 8'h00, 8'h00, 8'h80}, 32'd2000,  32'd1000,  4'd1, 1'b1, 1'b0, 1'b0},
        '{3'd2, {16'd0, 16'd0, 16'd3000, 16'd3000},  {8'h00, 8'h00, 8'h80, 8'h00}, 32'd5000,  32'd6000,  4'd2, 1'b0, 1'b1, 1'b0},
        '{3'd2, {16'd0, 16'd0, 16'd3000, 16'd3000},  {8'h00, 8'h00, 8'h80, 8'h02}, 32'd5000,  32'd6000,  4'd2, 1'b0, 1'b0, 1'b0},
        '{3'd2, {16'd0, 16'd0, 16'd3000, 16'd3000},  {8'h00, 8'h00, 8'h82, 8'h48}, 32'd5000,  32'd6000,  4'd2, 1'b0, 1'b0, 1'b0},
        '{3'd1, {16'd0, 16'd0, 16'd0, 16'd65024},    {8'h00, 8'h00, 8'h00, 8'hC0}, 32'd65024, 32'd65024, 4'd1, 1'b0, 1'b0, 1'b0},
        '{3'd2, {16'd0, 16'd0, 16'd65025, 16'd1000}, {8'h00, 8'h00, 8'h80, 8'h00}, 32'd66025, 32'd1000,  4'd1, 1'b0, 1'b0, 1'b1},
        '{3'd1, {16'd0, 16'd0, 16'd0, 16'd0},        {8'h00, 8'h00, 8'h00, 8'h80}, 32'd0,     32'd0,     4'd0, 1'b0, 1'b0, 1'b1},
        '{3'd1, {16'd0, 16'd0, 16'd0, 16'd500},      {8'h00, 8'h00, 8'h00, 8'h82}, 32'd600,   32'd500,   4'd1, 1'b1, 1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [31:0]      chain_base = '0;
    logic [TOT_W-1:0] exp_total = '0;
    logic             rd_req;
    logic [31:0]      rd_addr;
    logic             rd_rvalid = 1'b0;
    logic [63:0]      rd_data = '0;
    logic             req_valid;
    logic             req_ready = 1'b1;
    logic [31:0]      req_addr;
    logic [15:0]      req_len;
    logic [7:0]       req_flags;
    logic             busy;
    logic             done;
    logic [TOT_W-1:0] total_len;
    logic             underflow;
    logic             overflow;
    logic             len_err;
    logic             overrun_err;

    sgw_chain_walker #(
        .TOT_W(TOT_W), .MAX_DESC(MAX_DESC), .MAX_SEG_LEN(MAX_SEG)
    ) i_sgw_chain_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_base(chain_base),
        .exp_total(exp_total), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rvalid(rd_rvalid), .rd_data(rd_data), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .req_flags(req_flags), .busy(busy), .done(done), .total_len(total_len),
        .underflow(underflow), .overflow(overflow), .len_err(len_err),
        .overrun_err(overrun_err)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [63:0] mem [16];
    logic [31:0] mem_base = '0;
    logic [31:0] d_addr [16];
    logic [15:0] d_len [16];
    logic [7:0]  d_flag [16];
    logic        ready_alt = 1'b0;
    int req_cnt = 0;
    int req_base = 0;
    int fetch_cnt = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // descriptor memory with one cycle of read latency
    always @(posedge clk) begin
        rd_rvalid <= rd_req;
        if (rd_req) rd_data <= mem[4'((rd_addr - mem_base) >> 3)];
        req_ready <= ready_alt ? ~req_ready : 1'b1;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            summary();
        end
    end

    // request monitor: R1 field checks on every accepted region, R8 on stalls
    logic        stall_prev = 1'b0;
    logic [31:0] st_addr = '0;
    logic [15:0] st_len = '0;
    logic [7:0]  st_flag = '0;
    always @(negedge clk) begin
        if (rd_req) fetch_cnt++;
        if (stall_prev) begin
            chk(req_valid && req_addr == st_addr && req_len == st_len && req_flags == st_flag,
                "R8", "stalled request held", {req_valid, req_flags, req_len[7:0], req_addr[7:0]},
                {1'b1, st_flag, st_len[7:0], st_addr[7:0]});
        end
        stall_prev = req_valid && !req_ready;
        st_addr = req_addr; st_len = req_len; st_flag = req_flags;
        if (req_valid && req_ready) begin
            int k;
            k = req_cnt - req_base;
            chk(req_addr == d_addr[k], "R1", "region address", req_addr, d_addr[k]);
            chk(req_len == d_len[k], "R1", "region length", 32'(req_len), 32'(d_len[k]));
            chk(req_flags == d_flag[k], "R1", "region flags", 32'(req_flags), 32'(d_flag[k]));
            req_cnt++;
        end
    end

    task automatic load_desc(input int i, input logic [31:0] a, input logic [15:0] l,
                             input logic [7:0] f);
        mem[i] = {f, 8'hA5, l, a};
        d_addr[i] = a; d_len[i] = l; d_flag[i] = f;
    endtask

    task automatic run_walk(input logic [31:0] base, input logic [31:0] exp,
                            input int e_reqs, input logic [31:0] e_tot,
                            input logic e_un, input logic e_ov, input logic e_le,
                            input logic e_ovr, input int restart_at, input string tag);
        int t;
        int f0;
        mem_base = base;
        chain_base = base;
        exp_total = exp;
        req_base = req_cnt;
        f0 = fetch_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R9", {tag, " busy after start"}, 32'(busy), 32'd1);
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
            start = (t == restart_at);
            chain_base = (t == restart_at) ? base + 32'h80 : base;
            if (t == restart_at) exp_total = exp + 32'd7;
        end
        start = 1'b0;
        chain_base = base;
        exp_total = exp;
        chk(done == 1'b1, "R2", {tag, " done seen"}, 32'(done), 32'd1);
        chk(total_len == e_tot, "R3", {tag, " total"}, total_len, e_tot);
        chk(underflow == e_un, "R4", {tag, " underflow"}, 32'(underflow), 32'(e_un));
        chk(overflow == e_ov, "R5", {tag, " overflow"}, 32'(overflow), 32'(e_ov));
        chk(len_err == e_le, "R6", {tag, " length error"}, 32'(len_err), 32'(e_le));
        chk(overrun_err == e_ovr, "R7", {tag, " overrun"}, 32'(overrun_err), 32'(e_ovr));
        chk(req_cnt - req_base == e_reqs, "R2", {tag, " request count"},
            32'(req_cnt - req_base), 32'(e_reqs));
        chk(fetch_cnt - f0 == e_reqs + (e_le ? 1 : 0), "R2", {tag, " fetch count"},
            32'(fetch_cnt - f0), 32'(e_reqs + (e_le ? 1 : 0)));
        @(negedge clk);
        chk(!done && !busy, "R2", {tag, " done one cycle, idle after"},
            {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !req_valid && !rd_req, "R10", "control outputs in reset",
            {28'd0, busy, done, req_valid, rd_req}, 32'd0);
        chk(total_len == '0 && !underflow && !overflow && !len_err && !overrun_err,
            "R10", "results in reset", total_len, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10", "idle after reset release", {30'd0, busy, done}, 32'd0);

        // table of chains
        for (int c = 0; c < NV; c++) begin
            ready_alt = c[0];
            for (int i = 0; i < int'(VEC[c].n); i++)
                load_desc(i, 32'hF1E2_0000 + 32'(c) * 32'h1000 + 32'(i) * 32'h24 + 32'h3,
                          VEC[c].len[i], VEC[c].fl[i]);
            run_walk(32'h0004_0000 + 32'(c) * 32'h100, VEC[c].exp, int'(VEC[c].reqs),
                     VEC[c].tot, VEC[c].un, VEC[c].ov, VEC[c].le, 1'b0, -1,
                     $sformatf("case %0d", c));
        end
        ready_alt = 1'b0;

        // R7 no end marker within MAX_DESC regions: stop, no extra fetch
        for (int i = 0; i < MAX_DESC; i++) load_desc(i, 32'h1000 * 32'(i), 16'd100, 8'h10);
        load_desc(MAX_DESC, 32'hDEAD_0000, 16'd100, 8'h80);
        run_walk(32'h0009_0000, 32'd800, MAX_DESC, 32'd800, 1'b0, 1'b0, 1'b0, 1'b1, -1,
                 "R7 overrun");

        // R7 boundary: end marker on the last allowed region
        for (int i = 0; i < MAX_DESC; i++)
            load_desc(i, 32'h2000 * 32'(i), 16'd100, (i == MAX_DESC - 1) ? 8'h80 : 8'h10);
        run_walk(32'h000A_0000, 32'd800, MAX_DESC, 32'd800, 1'b0, 1'b0, 1'b0, 1'b0, -1,
                 "R7 boundary");

        // R9 start while busy is ignored (base and expected total changed too)
        load_desc(0, 32'h0101_0101, 16'd64, 8'h10);
        load_desc(1, 32'h0202_0202, 16'd64, 8'h90);
        run_walk(32'h000B_0000, 32'd128, 2, 32'd128, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R9 restart");

        summary();
    end

endmodule